// File: doc/BRIEF.md
# Enable-Gated Round-Robin Arbiter with Held Grant

This block chooses one winner from a set of request lines, whose number is a power of two. The winner is reported in two forms. One is a binary channel number. The other is a one-hot pulse on a per-channel vector that lasts one clock. A level flag, `granted`, rises together with the pulse and stays high for as long as the consumer keeps `arb_en` asserted. This lets the consumer decide when the next decision may start: it drops `arb_en` once it has taken the grant, then raises it again when it can accept another winner.

A parameter chooses between two priority schemes. In rotating priority, the search begins at the channel just after the previous winner and wraps around. In fixed priority, channel 0 always has precedence. Everything runs on one clock. A synchronous reset clears the channel output and restarts the rotation so that channel 0 is examined first.

Internally there is a two-state machine. In `ARB_OPEN`, the "take" transition to `ARB_HELD` happens when `arb_en` is high and at least one request is active. In `ARB_HELD`, the "release" transition back to `ARB_OPEN` happens when `arb_en` is low. Otherwise each state stays where it is. Reset forces `ARB_OPEN`.

Top module: `rr_hold_arbiter`

## Requirements
- R1: While `sreset` is high at a clock edge, the following edge leaves `granted` at 0, `win_pulse` at 0 and `win_chn` at 0. This holds even if a grant was being held. The next rotating search starts at channel 0.
- R2: While `arb_en` is low, no grant is made whatever the requests are. `granted` is 0 one cycle after any edge at which `arb_en` was low.
- R3: A grant is taken at an edge where the arbiter holds no grant, `arb_en` is high and `req` is nonzero. After that edge, `granted` is 1, `win_chn` holds the winner's index, and `win_pulse` has only bit `win_chn` set. Bit i of `req` and of `win_pulse` belong to channel i.
- R4: `win_pulse` is nonzero for exactly one cycle per grant.
- R5: While `granted` is 1 and `arb_en` stays high, no new grant occurs even if the requests change. `granted` stays 1, `win_pulse` stays 0 and `win_chn` keeps its value.
- R6: After an edge with `arb_en` low, `granted` is 0. A new grant may then be taken at a later edge where `arb_en` is high.
- R7: With `PRIO_FIXED` = 0, the winner is the first active request found by searching from (previous winner + 1) upward, modulo the number of channels.
- R8: With `PRIO_FIXED` = 1, the winner is the lowest-indexed active request.
- R9: With `arb_en` high and `req` all zero, no grant is made: `granted`, `win_pulse` and `win_chn` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sreset | input | 1 | Synchronous reset, active high |
| req | input | 1<<SEL_BITS | Request lines, bit i for channel i |
| arb_en | input | 1 | Allows a decision; must be dropped to end a held grant |
| granted | output | 1 | Level flag, high from the grant until arb_en is dropped |
| win_chn | output | SEL_BITS | Index of the last winner |
| win_pulse | output | 1<<SEL_BITS | One-cycle one-hot mark of the winner |

## Verification
Two instances, one rotating and one fixed, receive the same stimulus. The stimulus applies every nonzero request pattern after each of the four possible previous winners. This separates a search that starts after the last winner from one that starts at a fixed place, and it exercises wrap-around at the top channel. After each grant the request pattern is flipped while `arb_en` stays high, which shows whether the held state really blocks new decisions. Separate runs cover an all-zero request with `arb_en` high, requests with `arb_en` low, and a reset issued during a held grant, to confirm that the rotation restarts at channel 0.

// File: rtl/rhg_pkg.sv
package rhg_pkg;

    // Grant-holding machine: ARB_OPEN may take a winner, ARB_HELD waits for release.
    typedef enum logic [0:0] {
        ARB_OPEN = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_t;

endpackage

// File: rtl/rhg_pick.sv
// Combinational search: first active request above 'base', wrapping.
module rhg_pick #(
    parameter int W = 2,
    localparam int N = 1 << W
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] base,
    output logic         any,
    output logic [W-1:0] pick
);

    always_comb begin
        logic [W-1:0] idx;
        logic         hit;
        hit  = 1'b0;
        pick = '0;
        idx  = '0;
        for (int k = 1; k <= N; k++) begin
            idx = base + W'(k);      // W-bit add wraps modulo N
            if (!hit && req[idx]) begin
                pick = idx;
                hit  = 1'b1;
            end
        end
        any = hit;
    end

endmodule

// File: rtl/rhg_decode.sv
// Binary index to one-hot vector, gated.
module rhg_decode #(
    parameter int W = 2,
    localparam int N = 1 << W
) (
    input  logic [W-1:0] sel,
    input  logic         en,
    output logic [N-1:0] onehot
);

    always_comb begin
        onehot = '0;
        for (int i = 0; i < N; i++) begin
            if (en && (sel == W'(i))) onehot[i] = 1'b1;
        end
    end

endmodule

// File: rtl/rr_hold_arbiter.sv
module rr_hold_arbiter #(
    parameter int SEL_BITS   = 2,
    parameter int PRIO_FIXED = 0
) (
    input  logic                       clk,
    input  logic                       sreset,
    input  logic [(1<<SEL_BITS)-1:0]   req,
    input  logic                       arb_en,
    output logic                       granted,
    output logic [SEL_BITS-1:0]        win_chn,
    output logic [(1<<SEL_BITS)-1:0]   win_pulse
);

    import rhg_pkg::*;

    localparam int N_REQ = 1 << SEL_BITS;
    localparam logic [SEL_BITS-1:0] TOP_CHN = SEL_BITS'(N_REQ - 1);

    arb_state_t             state_q, state_d;
    logic [SEL_BITS-1:0]    search_base;
    logic                   req_any;
    logic [SEL_BITS-1:0]    pick_idx;
    logic                   take;
    logic [N_REQ-1:0]       pick_onehot;
    logic                   granted_q;
    logic [SEL_BITS-1:0]    chn_q;
    logic [N_REQ-1:0]       pulse_q;

    // Priority variant: fixed priority is a rotation pinned to the top channel.
    generate
        if (PRIO_FIXED != 0) begin : g_fixed
            assign search_base = TOP_CHN;
        end else begin : g_rotate
            logic [SEL_BITS-1:0] last_q;
            always_ff @(posedge clk) begin
                if (sreset)    last_q <= TOP_CHN;
                else if (take) last_q <= pick_idx;
            end
            assign search_base = last_q;
        end
    endgenerate

    rhg_pick #(.W(SEL_BITS)) u_pick (
        .req  (req),
        .base (search_base),
        .any  (req_any),
        .pick (pick_idx)
    );

    assign take = (state_q == ARB_OPEN) && arb_en && req_any;

    rhg_decode #(.W(SEL_BITS)) u_decode (
        .sel    (pick_idx),
        .en     (take),
        .onehot (pick_onehot)
    );

    // Next-state logic: take and release transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_OPEN: if (arb_en && req_any) state_d = ARB_HELD;
            ARB_HELD: if (!arb_en)           state_d = ARB_OPEN;
            default:                         state_d = ARB_OPEN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (sreset) state_q <= ARB_OPEN;
        else        state_q <= state_d;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (sreset) begin
            granted_q <= 1'b0;
            chn_q     <= '0;
            pulse_q   <= '0;
        end else begin
            granted_q <= (state_d == ARB_HELD);
            pulse_q   <= pick_onehot;
            if (take) chn_q <= pick_idx;
        end
    end

    assign granted   = granted_q;
    assign win_chn   = chn_q;
    assign win_pulse = pulse_q;

endmodule

// File: rtl/rr_hold_arbiter_chk.sv
module rr_hold_arbiter_chk #(
    parameter int W = 2,
    localparam int N = 1 << W
) (
    input logic         clk,
    input logic         sreset,
    input logic [N-1:0] req,
    input logic         arb_en,
    input logic         granted,
    input logic [W-1:0] win_chn,
    input logic [N-1:0] win_pulse
);

    a_r1_reset_clears: assert property (@(posedge clk)
        sreset |=> (!granted && win_chn == '0 && win_pulse == '0));

    a_r2_no_grant_when_off: assert property (@(posedge clk) disable iff (sreset)
        !arb_en |=> (!granted && win_pulse == '0));

    a_r3_pulse_onehot: assert property (@(posedge clk) disable iff (sreset)
        $onehot0(win_pulse));

    a_r3_pulse_matches_chn: assert property (@(posedge clk) disable iff (sreset)
        (win_pulse != '0) |-> (win_pulse[win_chn] && granted));

    a_r3_winner_requested: assert property (@(posedge clk) disable iff (sreset)
        (win_pulse != '0) |-> ((win_pulse & $past(req)) == win_pulse));

    a_r3_rise_has_pulse: assert property (@(posedge clk) disable iff (sreset)
        $rose(granted) |-> (win_pulse != '0));

    a_r4_pulse_single: assert property (@(posedge clk) disable iff (sreset)
        (win_pulse != '0) |=> (win_pulse == '0));

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (sreset)
        (granted && arb_en) |=> (granted && win_pulse == '0 && $stable(win_chn)));

    a_r9_idle_no_req: assert property (@(posedge clk) disable iff (sreset)
        (!granted && req == '0) |=> (!granted && win_pulse == '0 && $stable(win_chn)));

endmodule

bind rr_hold_arbiter rr_hold_arbiter_chk #(.W(SEL_BITS)) u_chk (
    .clk       (clk),
    .sreset    (sreset),
    .req       (req),
    .arb_en    (arb_en),
    .granted   (granted),
    .win_chn   (win_chn),
    .win_pulse (win_pulse)
);

// File: tb/rr_hold_arbiter_bench.sv
`timescale 1ns/1ps
module rr_hold_arbiter_bench;

    localparam int SB = 2;
    localparam int NB = 1 << SB;

    logic          clk = 1'b0;
    logic          sreset = 1'b1;
    logic [NB-1:0] req = '0;
    logic          arb_en = 1'b0;

    logic          g_rr, g_fx;
    logic [SB-1:0] c_rr, c_fx;
    logic [NB-1:0] p_rr, p_fx;

    int n_checks = 0;
    int n_fails  = 0;
    int lr       = NB - 1;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rr_hold_arbiter #(.SEL_BITS(SB), .PRIO_FIXED(0)) u_rr_hold_arbiter (
        .clk(clk), .sreset(sreset), .req(req), .arb_en(arb_en),
        .granted(g_rr), .win_chn(c_rr), .win_pulse(p_rr));

    rr_hold_arbiter #(.SEL_BITS(SB), .PRIO_FIXED(1)) u_rr_hold_arbiter_fx (
        .clk(clk), .sreset(sreset), .req(req), .arb_en(arb_en),
        .granted(g_fx), .win_chn(c_fx), .win_pulse(p_fx));

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_rot(input int last, input int p);
        for (int k = 1; k <= NB; k++) begin
            int i;
            i = (last + k) % NB;
            if (p[i]) return i;
        end
        return -1;
    endfunction

    function automatic int exp_fix(input int p);
        for (int i = 0; i < NB; i++) if (p[i]) return i;
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        sreset = 1'b1; arb_en = 1'b0; req = '0;
        @(negedge clk);
        sreset = 1'b0;
        lr = NB - 1;
    endtask

    task automatic grant_cycle(input int p);
        int er, ef;
        @(negedge clk);
        req = NB'(p); arb_en = 1'b1;
        @(negedge clk);
        er = exp_rot(lr, p);
        ef = exp_fix(p);
        check("R3 granted rot", int'(g_rr), 1);
        check("R7 chn rot", int'(c_rr), er);
        check("R3 pulse rot", int'(p_rr), 1 << er);
        check("R8 chn fix", int'(c_fx), ef);
        check("R8 pulse fix", int'(p_fx), 1 << ef);
        lr = er;
        req = ~NB'(p);
        @(negedge clk);
        check("R4 pulse gone rot", int'(p_rr), 0);
        check("R4 pulse gone fix", int'(p_fx), 0);
        check("R5 held rot", int'(g_rr), 1);
        check("R5 chn stable rot", int'(c_rr), er);
        check("R5 chn stable fix", int'(c_fx), ef);
        arb_en = 1'b0; req = '1;
        @(negedge clk);
        check("R6 released rot", int'(g_rr), 0);
        check("R6 released fix", int'(g_fx), 0);
        @(negedge clk);
        check("R2 off rot", int'(g_rr | (p_rr != 0)), 0);
        check("R2 off fix", int'(g_fx | (p_fx != 0)), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        do_reset();
        check("R1 granted", int'(g_rr | g_fx), 0);
        check("R1 chn", int'(c_rr) + int'(c_fx), 0);
        check("R1 pulse", int'(p_rr | p_fx), 0);

        // R9: enabled but nothing requested
        arb_en = 1'b1; req = '0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R9 no grant", int'(g_rr | g_fx | (p_rr != 0) | (p_fx != 0)), 0);
            check("R9 chn kept", int'(c_rr) + int'(c_fx), 0);
        end

        // R7/R8 sweep: every previous winner against every pattern
        for (int L = 0; L < NB; L++) begin
            for (int p = 1; p < (1 << NB); p++) begin
                do_reset();
                if (L != NB - 1) grant_cycle(1 << L);
                grant_cycle(p);
            end
        end

        // R1: reset during a held grant restarts rotation at channel 0
        do_reset();
        grant_cycle(4'b0110);
        @(negedge clk);
        req = 4'b0100; arb_en = 1'b1;
        @(negedge clk);
        check("R1 pre held", int'(g_rr), 1);
        sreset = 1'b1;
        @(negedge clk);
        sreset = 1'b0;
        check("R1 held cleared", int'(g_rr), 0);
        check("R1 chn cleared", int'(c_rr), 0);
        lr = NB - 1;
        arb_en = 1'b0;
        grant_cycle(4'b1111);
        check("R1 restart at 0", int'(c_rr), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule